// File: doc/BRIEF.md
# Double-Buffered SPI Byte Controller with Master Fallback

The block moves bytes over a four-wire SPI link as either the clocking master or a selected slave. Software sees three byte-wide registers: control, status and data. A byte written to the data register goes first into a transmit holding register. It moves into the shift register as soon as the shifter can take it. This double buffering removes any chance of a write collision, and a holding-empty status bit shows when the next byte may be written. A received byte is copied into a receive buffer, so the shifter is free for the next byte while software reads the previous one.

In master mode the serial clock is derived from the system clock through a 3-bit rate select. If the block is a master, is enabled, does not ignore its select pin, and another master pulls select low, the block clears its own master bit and becomes a slave. It also raises the mode-fault and transfer-done flags. It stays a slave until software sets the master bit again.

Transfers are MSB first. The serial clock idles low, data is sampled on the rising edge and changed on the falling edge.

The control state machine has six states: `ST_OFF` (disabled), `ST_M_IDLE` (master waiting for a byte), `ST_M_LOW` and `ST_M_HIGH` (the two half periods of a master bit), `ST_S_IDLE` (slave between bytes) and `ST_S_SHIFT` (slave inside a byte). Its transitions are:
- enable goes from `ST_OFF` to `ST_M_IDLE` or `ST_S_IDLE`, depending on the master bit;
- clearing enable returns any state to `ST_OFF`;
- holding-register full goes from `ST_M_IDLE` to `ST_M_LOW`;
- a divider tick alternates `ST_M_LOW` and `ST_M_HIGH`;
- at the last bit, `ST_M_HIGH` goes to `ST_M_LOW` if the holding register is full, otherwise to `ST_M_IDLE`;
- a mode fault, or software clearing the master bit, goes from any master state to `ST_S_IDLE`;
- the first selected rising edge goes from `ST_S_IDLE` to `ST_S_SHIFT`;
- the last rising edge, or select going high, goes from `ST_S_SHIFT` to `ST_S_IDLE`;
- setting the master bit goes from either slave state to `ST_M_IDLE`.

Top module: `spi_dualbuf_ctrl`

## Requirements
- R1: Register map by `reg_addr`: 0 is control, 1 is status, 2 is data (write goes to the holding register, read returns the receive buffer). Control bits are: 7 enable, 6 select-ignore, 5 master, 4 interrupt enable, 2:0 rate select. Status bits are: 7 done, 6 holding-empty, 5 mode fault. After reset, control reads 0x00, status reads 0x40, data reads 0x00, `irq` is 0 and all three drive enables are 0.
- R2: In master mode one serial clock period lasts this many system clocks, by rate select: 000 gives 16, 001 gives 24, 010 gives 48, 011 gives 96, 100 gives 8, 101 gives 4, 110 gives 6, 111 gives 12.
- R3: A data write while status bit 6 is 0 is ignored. Bit 6 clears when a write is accepted and sets again when the byte moves into the shift register.
- R4: A master starts a transfer by itself whenever the shifter is idle and the holding register is full. A byte written while the previous byte is still shifting follows it with no idle clock period.
- R5: A master transfer sends the byte MSB first on `mosi_o`. It samples `miso_i` on each rising `sclk_o` edge. When the byte ends, the received byte appears at data read and status bit 7 sets. `sclk_o` is low while idle.
- R6: When the block is an enabled master with select-ignore 0 and `ss_n_i` goes low, the master bit clears and status bits 7 and 5 set.
- R7: As a slave, `sclk_oe` and `mosi_oe` are 0. `miso_oe` is 1 only while `ss_n_i` is low.
- R8: After a fallback the master bit stays 0, even after `ss_n_i` returns high, until software writes it to 1. The block then drives the clock again.
- R9: With select-ignore set, a low `ss_n_i` leaves a master's control bits and status unchanged.
- R10: As a slave selected by `ss_n_i`, the block shifts in `mosi_i` on rising `sclk_i` and presents the preloaded holding byte MSB first on `miso_o`. A finished byte goes to the receive buffer, which keeps the previous byte while the next byte shifts in.
- R11: Writing 1 to status bit 7 or bit 5 clears that flag, and writing 0 leaves it unchanged. `irq` is 1 exactly when control bit 4 is set and status bit 7 or 5 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 2 | Register select |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data for `reg_addr` |
| irq | output | 1 | Interrupt request |
| sclk_i | input | 1 | Serial clock from an external master |
| sclk_o | output | 1 | Serial clock driven as master |
| sclk_oe | output | 1 | Drive enable for `sclk_o` |
| mosi_i | input | 1 | Serial data in as slave |
| mosi_o | output | 1 | Serial data out as master |
| mosi_oe | output | 1 | Drive enable for `mosi_o` |
| miso_i | input | 1 | Serial data in as master |
| miso_o | output | 1 | Serial data out as slave |
| miso_oe | output | 1 | Drive enable for `miso_o` |
| ss_n_i | input | 1 | Active-low slave select |

## Verification
Master transfers are run with complementary bytes and with single-bit bytes in both directions, so a reversed bit order or an off-by-one shift shows on the captured values. Every rate-select code is timed edge to edge, which separates the eight divisors from one another. A byte queued behind a byte that is still shifting is timed across the boundary to expose any idle gap. The slave path is driven by a bench master, and the receive buffer is read in the middle of a second byte to tell a buffered receive path from one that exposes the live shifter.

// File: rtl/spi_dualbuf_pkg.sv
package spi_dualbuf_pkg;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_M_IDLE,
        ST_M_LOW,
        ST_M_HIGH,
        ST_S_IDLE,
        ST_S_SHIFT
    } spi_state_e;

    localparam int CTL_EN   = 7;
    localparam int CTL_SSIG = 6;
    localparam int CTL_MSTR = 5;
    localparam int CTL_IEN  = 4;

    localparam int STA_DONE = 7;
    localparam int STA_THRE = 6;
    localparam int STA_MODF = 5;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_STAT = 2'd1;
    localparam logic [1:0] ADDR_DATA = 2'd2;

    // System clocks per half serial-clock period for each rate code.
    function automatic int half_period(input logic [2:0] sel);
        int h;
        unique case (sel)
            3'b000:  h = 8;
            3'b001:  h = 12;
            3'b010:  h = 24;
            3'b011:  h = 48;
            3'b100:  h = 4;
            3'b101:  h = 2;
            3'b110:  h = 3;
            default: h = 6;
        endcase
        return h;
    endfunction

endpackage

// File: rtl/spi_in_sync.sv
module spi_in_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] rst_val,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] pipe [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    pipe[s] <= rst_val;
                end else begin
                    if (s == 0) pipe[s] <= d;
                    else        pipe[s] <= pipe[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/spi_rate_gen.sv
module spi_rate_gen
    import spi_dualbuf_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic [2:0] sel,
    output logic       tick
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit;

    assign limit = CNT_W'(half_period(sel) - 1);
    assign tick  = run && (cnt_q == limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/spi_dualbuf_ctrl.sv
module spi_dualbuf_ctrl
    import spi_dualbuf_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2,
    parameter int DIV_CNT_W   = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        reg_addr,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq,
    input  logic              sclk_i,
    output logic              sclk_o,
    output logic              sclk_oe,
    input  logic              mosi_i,
    output logic              mosi_o,
    output logic              mosi_oe,
    input  logic              miso_i,
    output logic              miso_o,
    output logic              miso_oe,
    input  logic              ss_n_i
);
    localparam int          BIT_W = $clog2(DATA_W);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);

    spi_state_e        state_q, state_d;
    logic [DATA_W-1:0] ctrl_q, thr_q, shift_q, rx_buf_q;
    logic              done_q, fault_q, thr_empty_q, rx_bit_q;
    logic              sclk_q, out_bit_q, tx_loaded_q, sclk_prev_q;
    logic [BIT_W-1:0]  bit_cnt_q;

    // Synchronised pins
    logic sclk_s, mosi_s, ss_s;

    spi_in_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .rst_val (3'b001),
        .d       ({sclk_i, mosi_i, ss_n_i}),
        .q       ({sclk_s, mosi_s, ss_s})
    );

    logic en, ssig, mstr, ien;
    assign en   = ctrl_q[CTL_EN];
    assign ssig = ctrl_q[CTL_SSIG];
    assign mstr = ctrl_q[CTL_MSTR];
    assign ien  = ctrl_q[CTL_IEN];

    logic in_master, in_slave, run, tick;
    assign in_master = (state_q == ST_M_IDLE) || (state_q == ST_M_LOW) || (state_q == ST_M_HIGH);
    assign in_slave  = (state_q == ST_S_IDLE) || (state_q == ST_S_SHIFT);
    assign run       = (state_q == ST_M_LOW) || (state_q == ST_M_HIGH);

    spi_rate_gen #(.CNT_W(DIV_CNT_W)) u_rate (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .sel   (ctrl_q[2:0]),
        .tick  (tick)
    );

    // Register strobes
    logic wr_ctrl, wr_stat, wr_data, thr_accept;
    assign wr_ctrl    = reg_wr && (reg_addr == ADDR_CTRL);
    assign wr_stat    = reg_wr && (reg_addr == ADDR_STAT);
    assign wr_data    = reg_wr && (reg_addr == ADDR_DATA);
    assign thr_accept = wr_data && thr_empty_q;

    // Master events
    logic fault_hit, m_ok, m_sample, m_shift, m_last, m_load;
    assign fault_hit = in_master && en && !ssig && mstr && !ss_s;
    assign m_ok      = en && mstr && !fault_hit;
    assign m_sample  = (state_q == ST_M_LOW)  && tick && m_ok;
    assign m_shift   = (state_q == ST_M_HIGH) && tick && m_ok;
    assign m_last    = m_shift && (bit_cnt_q == LAST_BIT);
    assign m_load    = m_ok && !thr_empty_q && ((state_q == ST_M_IDLE) || m_last);

    // Slave events
    logic s_ok, s_sel, s_rise, s_fall, s_shift, s_last, s_drop, s_load;
    assign s_ok    = en && !mstr;
    assign s_sel   = !ss_s;
    assign s_rise  = sclk_s && !sclk_prev_q;
    assign s_fall  = !sclk_s && sclk_prev_q;
    assign s_shift = in_slave && s_ok && s_sel && s_rise;
    assign s_last  = (state_q == ST_S_SHIFT) && s_shift && (bit_cnt_q == LAST_BIT);
    assign s_drop  = (state_q == ST_S_SHIFT) && s_ok && s_sel && s_fall;
    assign s_load  = (state_q == ST_S_IDLE) && s_ok && !thr_empty_q && !tx_loaded_q && !s_shift;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: begin
                if (en) state_d = mstr ? ST_M_IDLE : ST_S_IDLE;
            end
            ST_M_IDLE: begin
                if (!en)                    state_d = ST_OFF;
                else if (fault_hit || !mstr) state_d = ST_S_IDLE;
                else if (!thr_empty_q)       state_d = ST_M_LOW;
            end
            ST_M_LOW: begin
                if (!en)                    state_d = ST_OFF;
                else if (fault_hit || !mstr) state_d = ST_S_IDLE;
                else if (tick)               state_d = ST_M_HIGH;
            end
            ST_M_HIGH: begin
                if (!en)                    state_d = ST_OFF;
                else if (fault_hit || !mstr) state_d = ST_S_IDLE;
                else if (tick) begin
                    if (bit_cnt_q != LAST_BIT) state_d = ST_M_LOW;
                    else if (!thr_empty_q)     state_d = ST_M_LOW;
                    else                       state_d = ST_M_IDLE;
                end
            end
            ST_S_IDLE: begin
                if (!en)          state_d = ST_OFF;
                else if (mstr)    state_d = ST_M_IDLE;
                else if (s_shift) state_d = ST_S_SHIFT;
            end
            ST_S_SHIFT: begin
                if (!en)                  state_d = ST_OFF;
                else if (mstr)            state_d = ST_M_IDLE;
                else if (!s_sel || s_last) state_d = ST_S_IDLE;
            end
            default: state_d = ST_OFF;
        endcase
    end

    logic busy_next, slave_next;
    assign busy_next  = (state_d == ST_M_LOW) || (state_d == ST_M_HIGH) || (state_d == ST_S_SHIFT);
    assign slave_next = (state_d == ST_S_IDLE) || (state_d == ST_S_SHIFT);

    // Datapath and flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q      <= '0;
            done_q      <= 1'b0;
            fault_q     <= 1'b0;
            thr_q       <= '0;
            thr_empty_q <= 1'b1;
            shift_q     <= '0;
            rx_bit_q    <= 1'b0;
            rx_buf_q    <= '0;
            bit_cnt_q   <= '0;
            sclk_q      <= 1'b0;
            out_bit_q   <= 1'b0;
            tx_loaded_q <= 1'b0;
            sclk_prev_q <= 1'b0;
        end else begin
            if (wr_ctrl)   ctrl_q <= reg_wdata;
            if (fault_hit) ctrl_q[CTL_MSTR] <= 1'b0;

            if (wr_stat && reg_wdata[STA_DONE]) done_q  <= 1'b0;
            if (wr_stat && reg_wdata[STA_MODF]) fault_q <= 1'b0;
            if (m_last || s_last || fault_hit)  done_q  <= 1'b1;
            if (fault_hit)                      fault_q <= 1'b1;

            if (thr_accept) begin
                thr_q       <= reg_wdata;
                thr_empty_q <= 1'b0;
            end else if (m_load || s_load) begin
                thr_empty_q <= 1'b1;
            end

            if (m_load || s_load) shift_q <= thr_q;
            else if (m_shift)     shift_q <= {shift_q[DATA_W-2:0], rx_bit_q};
            else if (s_shift)     shift_q <= {shift_q[DATA_W-2:0], mosi_s};

            if (m_sample) rx_bit_q <= miso_i;

            if (m_last)      rx_buf_q <= {shift_q[DATA_W-2:0], rx_bit_q};
            else if (s_last) rx_buf_q <= {shift_q[DATA_W-2:0], mosi_s};

            if (m_load || s_last || !busy_next) bit_cnt_q <= '0;
            else if (m_shift || s_shift)        bit_cnt_q <= bit_cnt_q + 1'b1;

            if (!((state_d == ST_M_LOW) || (state_d == ST_M_HIGH))) sclk_q <= 1'b0;
            else if (m_sample)                                      sclk_q <= 1'b1;
            else if (m_shift)                                       sclk_q <= 1'b0;

            if (s_load)      out_bit_q <= thr_q[DATA_W-1];
            else if (s_drop) out_bit_q <= shift_q[DATA_W-1];

            if (s_load)                        tx_loaded_q <= 1'b1;
            else if (s_last || !slave_next)    tx_loaded_q <= 1'b0;

            sclk_prev_q <= sclk_s;
        end
    end

    // Outputs
    always_comb begin
        sclk_oe = 1'b0;
        mosi_oe = 1'b0;
        miso_oe = 1'b0;
        unique case (state_q)
            ST_M_IDLE, ST_M_LOW, ST_M_HIGH: begin
                sclk_oe = 1'b1;
                mosi_oe = 1'b1;
            end
            ST_S_IDLE, ST_S_SHIFT: begin
                miso_oe = s_sel;
            end
            default: ;
        endcase
    end

    assign sclk_o = sclk_q;
    assign mosi_o = shift_q[DATA_W-1];
    assign miso_o = out_bit_q;
    assign irq    = ien && (done_q || fault_q);

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            ADDR_CTRL: reg_rdata = ctrl_q;
            ADDR_STAT: begin
                reg_rdata[STA_DONE] = done_q;
                reg_rdata[STA_THRE] = thr_empty_q;
                reg_rdata[STA_MODF] = fault_q;
            end
            ADDR_DATA: reg_rdata = rx_buf_q;
            default:   reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/spi_dualbuf_chk.sv
module spi_dualbuf_chk
    import spi_dualbuf_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int BIT_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input spi_state_e        state_q,
    input logic              tick,
    input logic [BIT_W-1:0]  bit_cnt_q,
    input logic [DATA_W-1:0] ctrl_q,
    input logic [DATA_W-1:0] thr_q,
    input logic              done_q,
    input logic              fault_q,
    input logic              thr_empty_q,
    input logic              ss_s,
    input logic              reg_wr,
    input logic [1:0]        reg_addr,
    input logic              sclk_o,
    input logic              sclk_oe,
    input logic              mosi_oe
);
    logic master_st, slave_st, ctrl_wr;
    assign master_st = (state_q == ST_M_IDLE) || (state_q == ST_M_LOW) || (state_q == ST_M_HIGH);
    assign slave_st  = (state_q == ST_S_IDLE) || (state_q == ST_S_SHIFT);
    assign ctrl_wr   = reg_wr && (reg_addr == ADDR_CTRL);

    AST_FULL_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == ADDR_DATA && !thr_empty_q) |=> $stable(thr_q)); // R3

    AST_IDLE_CLOCK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_M_IDLE) |-> !sclk_o); // R5

    AST_BYTE_END_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_M_HIGH && tick && bit_cnt_q == BIT_W'(DATA_W-1)
         && ctrl_q[CTL_EN] && ctrl_q[CTL_MSTR]) |=> done_q); // R5

    AST_FAULT_DROPS_MASTER: assert property (@(posedge clk) disable iff (!rst_n)
        (master_st && ctrl_q[CTL_EN] && !ctrl_q[CTL_SSIG] && ctrl_q[CTL_MSTR] && !ss_s)
        |=> (!ctrl_q[CTL_MSTR] && fault_q && done_q)); // R6

    AST_SLAVE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        slave_st |-> (!sclk_oe && !mosi_oe)); // R7

    AST_SLAVE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_q[CTL_MSTR] && !ctrl_wr) |=> !ctrl_q[CTL_MSTR]); // R8

    AST_IGNORE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q[CTL_SSIG] && ctrl_q[CTL_MSTR] && !ctrl_wr) |=> ctrl_q[CTL_MSTR]); // R9
endmodule

bind spi_dualbuf_ctrl spi_dualbuf_chk #(.DATA_W(DATA_W), .BIT_W(BIT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .state_q     (state_q),
    .tick        (tick),
    .bit_cnt_q   (bit_cnt_q),
    .ctrl_q      (ctrl_q),
    .thr_q       (thr_q),
    .done_q      (done_q),
    .fault_q     (fault_q),
    .thr_empty_q (thr_empty_q),
    .ss_s        (ss_s),
    .reg_wr      (reg_wr),
    .reg_addr    (reg_addr),
    .sclk_o      (sclk_o),
    .sclk_oe     (sclk_oe),
    .mosi_oe     (mosi_oe)
);

// File: tb/test_spi_dualbuf_ctrl.sv
`timescale 1ns/1ps
module test_spi_dualbuf_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       irq;
    logic       sclk_i = 1'b0, mosi_i = 1'b0, miso_i = 1'b0, ss_n_i = 1'b1;
    logic       sclk_o, sclk_oe, mosi_o, mosi_oe, miso_o, miso_oe;

    int checks = 0;
    int fails  = 0;
    bit ended  = 1'b0;

    always #5 clk = ~clk;

    spi_dualbuf_ctrl i_spi_dualbuf_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
        .sclk_i(sclk_i), .sclk_o(sclk_o), .sclk_oe(sclk_oe),
        .mosi_i(mosi_i), .mosi_o(mosi_o), .mosi_oe(mosi_oe),
        .miso_i(miso_i), .miso_o(miso_o), .miso_oe(miso_oe),
        .ss_n_i(ss_n_i)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic chk_eq(input string req, input int act, input int exp);
        chk(act == exp, req, act, exp);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_done();
        logic [7:0] s;
        for (int n = 0; n < 5000; n++) begin
            rd(2'd1, s);
            if (s[7]) break;
        end
    endtask

    function automatic int exp_div(input int sel);
        case (sel)
            0: return 16; 1: return 24; 2: return 48; 3: return 96;
            4: return 8;  5: return 4;  6: return 6;  default: return 12;
        endcase
    endfunction

    // Bench acts as the slave on the far end of a master transfer
    task automatic master_capture(input logic [7:0] sb, output logic [7:0] seen);
        miso_i = sb[7];
        for (int i = 0; i < 8; i++) begin
            @(posedge sclk_o);
            seen[7-i] = mosi_o;
            if (i < 7) begin
                @(negedge sclk_o);
                miso_i = sb[6-i];
            end
        end
    endtask

    // Bench acts as an external master clocking the block as slave
    task automatic ext_bits(input logic [7:0] d, input int first, input int last,
                            inout logic [7:0] got);
        for (int i = first; i <= last; i++) begin
            mosi_i = d[7-i];
            repeat (8) @(negedge clk);
            got[7-i] = miso_o;
            sclk_i = 1'b1;
            repeat (8) @(negedge clk);
            sclk_i = 1'b0;
        end
    endtask

    task automatic t_reset();
        logic [7:0] v;
        rd(2'd0, v); chk_eq("R1 ctrl reset", v, 8'h00);
        rd(2'd1, v); chk_eq("R1 status reset", v, 8'h40);
        rd(2'd2, v); chk_eq("R1 data reset", v, 8'h00);
        chk_eq("R1 irq reset", irq, 0);
        chk_eq("R1 drive enables reset", {sclk_oe, mosi_oe, miso_oe}, 0);
    endtask

    task automatic t_rates();
        realtime t0, t1;
        for (int sel = 0; sel < 8; sel++) begin
            wr(2'd0, 8'hA0 | 8'(sel));
            wr(2'd2, 8'h5A);
            @(posedge sclk_o); t0 = $realtime;
            @(posedge sclk_o); t1 = $realtime;
            chk_eq($sformatf("R2 period sel=%0d", sel), int'((t1 - t0) / 10.0), exp_div(sel));
            wait_done();
            wr(2'd1, 8'hA0);
        end
    endtask

    task automatic t_master(input logic [7:0] tx, input logic [7:0] sb);
        logic [7:0] seen, v;
        wr(2'd0, 8'hA5);
        wr(2'd2, tx);
        master_capture(sb, seen);
        chk_eq("R5 mosi MSB-first byte", seen, tx);
        wait_done();
        rd(2'd2, v); chk_eq("R5 received byte", v, sb);
        rd(2'd1, v); chk_eq("R5 done and empty", v & 8'hC0, 8'hC0);
        chk_eq("R5 clock idles low", sclk_o, 0);
        wr(2'd1, 8'hA0);
    endtask

    task automatic t_ignore_full();
        logic [7:0] seen, v;
        wr(2'd0, 8'h00);
        wr(2'd2, 8'hA5);
        rd(2'd1, v); chk_eq("R3 holding not empty", v[6], 0);
        wr(2'd2, 8'h5A);
        wr(2'd0, 8'hA5);
        master_capture(8'h00, seen);
        chk_eq("R3 second write ignored", seen, 8'hA5);
        wait_done();
        rd(2'd1, v); chk_eq("R3 holding empty again", v[6], 1);
        wr(2'd1, 8'hA0);
    endtask

    task automatic t_back_to_back();
        logic [7:0] v;
        realtime t0, t1;
        wr(2'd0, 8'hA0);
        wr(2'd2, 8'h11);
        for (int n = 0; n < 100; n++) begin
            rd(2'd1, v);
            if (v[6]) break;
        end
        wr(2'd2, 8'h22);
        @(posedge sclk_o); t0 = $realtime;
        repeat (15) @(posedge sclk_o);
        t1 = $realtime;
        chk_eq("R4 no gap over 16 bits", int'((t1 - t0) / 10.0), 15 * 16);
        wait_done();
        wr(2'd1, 8'hA0);
    endtask

    task automatic t_fault();
        logic [7:0] v;
        wr(2'd0, 8'hB5);
        wr(2'd1, 8'hA0);
        ss_n_i = 1'b0;
        repeat (6) @(negedge clk);
        rd(2'd0, v); chk_eq("R6 master bit cleared", v, 8'h95);
        rd(2'd1, v); chk_eq("R6 done and fault set", v, 8'hE0);
        chk_eq("R11 irq on fault", irq, 1);
        chk_eq("R7 enables as slave", {sclk_oe, mosi_oe, miso_oe}, 3'b001);
        ss_n_i = 1'b1;
        repeat (6) @(negedge clk);
        rd(2'd0, v); chk_eq("R8 stays slave", v, 8'h95);
        chk_eq("R7 miso released", miso_oe, 0);
        wr(2'd1, 8'h00);
        rd(2'd1, v); chk_eq("R11 write 0 keeps flags", v, 8'hE0);
        wr(2'd0, 8'h85);
        chk_eq("R11 irq masked", irq, 0);
        wr(2'd0, 8'h95);
        wr(2'd1, 8'h80);
        rd(2'd1, v); chk_eq("R11 clear done", v, 8'h60);
        chk_eq("R11 irq from fault alone", irq, 1);
        wr(2'd1, 8'h20);
        rd(2'd1, v); chk_eq("R11 clear fault", v, 8'h40);
        chk_eq("R11 irq low", irq, 0);
        wr(2'd0, 8'hB5);
        repeat (2) @(negedge clk);
        chk_eq("R8 master restored", {sclk_oe, mosi_oe}, 2'b11);
    endtask

    task automatic t_ss_ignore();
        logic [7:0] v;
        wr(2'd0, 8'hE5);
        ss_n_i = 1'b0;
        repeat (6) @(negedge clk);
        rd(2'd0, v); chk_eq("R9 ctrl unchanged", v, 8'hE5);
        rd(2'd1, v); chk_eq("R9 no flags", v, 8'h40);
        chk_eq("R9 still drives clock", sclk_oe, 1);
        ss_n_i = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_slave();
        logic [7:0] got, v;
        got = 8'h00;
        wr(2'd0, 8'h80);
        wr(2'd1, 8'hA0);
        wr(2'd2, 8'h96);
        repeat (3) @(negedge clk);
        rd(2'd1, v); chk_eq("R10 holding moved to shifter", v[6], 1);
        ss_n_i = 1'b0;
        repeat (4) @(negedge clk);
        chk_eq("R7 miso driven when selected", miso_oe, 1);
        ext_bits(8'h5A, 0, 7, got);
        chk_eq("R10 miso byte", got, 8'h96);
        repeat (4) @(negedge clk);
        rd(2'd2, v); chk_eq("R10 received byte", v, 8'h5A);
        rd(2'd1, v); chk_eq("R10 done set", v[7], 1);
        ext_bits(8'hC3, 0, 3, got);
        rd(2'd2, v); chk_eq("R10 buffer holds during next byte", v, 8'h5A);
        ext_bits(8'hC3, 4, 7, got);
        repeat (4) @(negedge clk);
        rd(2'd2, v); chk_eq("R10 second byte", v, 8'hC3);
        ss_n_i = 1'b1;
        repeat (4) @(negedge clk);
        wr(2'd0, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_rates();
        t_master(8'hC3, 8'h3C);
        t_master(8'h01, 8'h80);
        t_ignore_full();
        t_back_to_back();
        t_fault();
        t_ss_ignore();
        t_slave();
        if (!ended) begin
            ended = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        #1_500_000;
        if (!ended) begin
            ended = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule